// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block moves a programmed number of data items from a source address to a destination address over a simple request/acknowledge memory port. Each item moves as one beat: a read of the source address followed by a write of the same data to the destination. Software programs a peripheral-side address, a memory-side address and an item count. It then sets the enable bit in the channel configuration word, and the channel runs until the count reaches zero. A direction bit picks which address is the source. A memory-to-memory bit removes the wait for a peripheral request. A circular bit reloads the count and both addresses at the end of every pass, so the channel repeats the pass.

Three events are recorded in sticky flags: half of the items moved, all items moved, and a bus error. Each flag has its own enable into the interrupt output. Flags are cleared by writing ones to a separate clear register. The sequencer has five states. IDLE waits for enable with a nonzero count. ARM waits for a peripheral request, or for nothing in memory-to-memory mode. READ holds the read request until it is acknowledged. WRITE holds the write request until it is acknowledged. STEP updates the count, the addresses and the flags.

The transitions are:
- IDLE→ARM when the enable bit is set and the count is nonzero.
- ARM→READ when a request is present or memory-to-memory mode is set.
- ARM→IDLE when the enable bit is cleared.
- READ→WRITE on an acknowledge without error.
- WRITE→STEP on an acknowledge without error.
- READ or WRITE→IDLE on an error acknowledge.
- STEP→IDLE after the last item when circular mode is off, or when the enable bit has been cleared.
- STEP→ARM otherwise.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the status, configuration, count and address registers read 0, no memory request is raised and irq is low.
- R2: The register byte offsets are fixed: 0x00 status (read), 0x04 flag clear (write), and, with base B = 8 + 20·CH_IDX, B configuration, B+4 count, B+8 peripheral-side address, B+12 memory-side address. Writes to the count and address registers are ignored while the enable bit is set.
- R3: Configuration bit 4 (dir) set to 0 reads from the peripheral-side address and writes to the memory-side address; set to 1 it reads from the memory-side address and writes to the peripheral-side address. Every write beat carries the data returned by the read beat just before it.
- R4: With configuration bit 10 (memory-to-memory) clear, no read beat starts while per_req is low. With bit 10 set, beats run back to back with no request.
- R5: The count decrements once per completed beat. When it reaches zero with circular mode off, the enable bit (bit 0) clears and the done flag (status bit 1) sets.
- R6: Beat size is configuration bits 9:8 (0 = 1 byte, 1 = 2 bytes, 2 and 3 = 4 bytes), driven on mem_size. After each beat, the peripheral-side address advances by the beat size when bit 6 is set and the memory-side address advances when bit 7 is set. An address whose bit is clear stays fixed.
- R7: With circular mode (bit 5) set, the beat that brings the count to zero reloads the count and both addresses to their programmed values, and transfers continue. Clearing bit 5 while the channel runs ends it at the end of the current pass.
- R8: The half flag (status bit 0) sets when the remaining count after a beat equals the programmed count divided by two, rounded down.
- R9: An error acknowledge sets the error flag (status bit 2), clears the enable bit, stops the channel without a write for that item, and leaves the count unchanged.
- R10: Writing 1 to bit 0, 1 or 2 of the clear register clears the matching flag. Writing 1 to bit 3 clears all three flags. Zero bits have no effect. Status bit 3 reads as the OR of the three flags.
- R11: irq equals (half AND bit 2) OR (done AND bit 1) OR (error AND bit 3) of the configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | REG_AW | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| per_req | input | 1 | Peripheral transfer request (level) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_size | output | 2 | Beat size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Beat acknowledge |
| mem_err | input | 1 | Error response, valid with mem_ack |
| irq | output | 1 | Channel interrupt |

## Verification
The hardest situations to reach from the ports come from software changing the configuration while beats are in flight. One is clearing circular mode partway through a pass. The other is an error response landing in the middle of a transfer, after the half flag has already fired. The bench handles the first by watching the write beats at its memory model and rewriting the configuration once a fixed number of writes has been seen. It then checks that the pass ends exactly at its boundary. For the second, it arms an error on the read address of the third item, and then checks the flags, the stopped count and the number of writes.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int REG_DW = 32;
    localparam int CFG_W  = 11;

    // status / flag bit positions
    localparam int FLG_HALF = 0;
    localparam int FLG_DONE = 1;
    localparam int FLG_ERR  = 2;
    localparam int FLG_ALL  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_READ,
        ST_WRITE,
        ST_STEP
    } seq_state_t;

    // configuration word, bit 0 is the enable
    typedef struct packed {
        logic       m2m;      // 10
        logic [1:0] size;     // 9:8
        logic       minc;     // 7
        logic       pinc;     // 6
        logic       circ;     // 5
        logic       dir;      // 4
        logic       err_ie;   // 3
        logic       half_ie;  // 2
        logic       done_ie;  // 1
        logic       en;       // 0
    } chan_cfg_t;

    function automatic logic [2:0] beat_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    beat_bytes = 3'd1;
            2'd1:    beat_bytes = 3'd2;
            default: beat_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int REG_AW = 8,
    parameter int CH_IDX = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [REG_DW-1:0]   reg_wdata,
    output logic [REG_DW-1:0]   reg_rdata,
    input  logic                step,
    input  logic                stop,
    input  logic                err_hit,
    output chan_cfg_t           cfg_q,
    output logic [CNT_W-1:0]    cnt_q,
    output logic [ADDR_W-1:0]   paddr_q,
    output logic [ADDR_W-1:0]   maddr_q,
    output logic [2:0]          flags_q,
    output logic                irq
);

    localparam int CH_BASE = 8 + 20 * CH_IDX;
    localparam logic [REG_AW-1:0] OFF_STS = REG_AW'(0);
    localparam logic [REG_AW-1:0] OFF_CLR = REG_AW'(4);
    localparam logic [REG_AW-1:0] OFF_CFG = REG_AW'(CH_BASE);
    localparam logic [REG_AW-1:0] OFF_CNT = REG_AW'(CH_BASE + 4);
    localparam logic [REG_AW-1:0] OFF_PA  = REG_AW'(CH_BASE + 8);
    localparam logic [REG_AW-1:0] OFF_MA  = REG_AW'(CH_BASE + 12);

    logic [CNT_W-1:0] cnt_init;
    logic [2:0]       flags_d;
    logic             last_beat;
    logic [2:0]       clr_mask;

    assign last_beat = (cnt_q == CNT_W'(1));

    // configuration and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            cnt_q    <= '0;
            cnt_init <= '0;
            paddr_q  <= '0;
            maddr_q  <= '0;
        end else begin
            if (reg_we && reg_addr == OFF_CFG)
                cfg_q <= chan_cfg_t'(reg_wdata[CFG_W-1:0]);
            if (reg_we && !cfg_q.en) begin
                if (reg_addr == OFF_CNT) begin
                    cnt_q    <= reg_wdata[CNT_W-1:0];
                    cnt_init <= reg_wdata[CNT_W-1:0];
                end
                if (reg_addr == OFF_PA)
                    paddr_q <= reg_wdata[ADDR_W-1:0];
                if (reg_addr == OFF_MA)
                    maddr_q <= reg_wdata[ADDR_W-1:0];
            end
            if (step) begin
                if (last_beat && cfg_q.circ)
                    cnt_q <= cnt_init;
                else
                    cnt_q <= cnt_q - CNT_W'(1);
            end
            if (stop)
                cfg_q.en <= 1'b0;
        end
    end

    // flag next value: clear first, hardware set wins
    always_comb begin
        clr_mask = reg_wdata[FLG_ALL] ? 3'b111 : reg_wdata[2:0];
        flags_d  = flags_q;
        if (reg_we && reg_addr == OFF_CLR)
            flags_d = flags_q & ~clr_mask;
        if (step) begin
            if ((cnt_q - CNT_W'(1)) == (cnt_init >> 1))
                flags_d[FLG_HALF] = 1'b1;
            if (last_beat)
                flags_d[FLG_DONE] = 1'b1;
        end
        if (err_hit)
            flags_d[FLG_ERR] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    always_comb begin
        case (reg_addr)
            OFF_STS: reg_rdata = REG_DW'({|flags_q, flags_q});
            OFF_CFG: reg_rdata = REG_DW'(cfg_q);
            OFF_CNT: reg_rdata = REG_DW'(cnt_q);
            OFF_PA:  reg_rdata = REG_DW'(paddr_q);
            OFF_MA:  reg_rdata = REG_DW'(maddr_q);
            default: reg_rdata = '0;
        endcase
    end

    assign irq = (flags_q[FLG_HALF] & cfg_q.half_ie)
               | (flags_q[FLG_DONE] & cfg_q.done_ie)
               | (flags_q[FLG_ERR]  & cfg_q.err_ie);

endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              dir,
    input  logic              pinc,
    input  logic              minc,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] paddr_init,
    input  logic [ADDR_W-1:0] maddr_init,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);

    localparam int NPTR = 2;   // 0: peripheral side, 1: memory side

    logic [ADDR_W-1:0] init_v [NPTR];
    logic              inc_v  [NPTR];
    logic [ADDR_W-1:0] cur_v  [NPTR];
    logic [ADDR_W-1:0] stride;

    assign init_v[0] = paddr_init;
    assign init_v[1] = maddr_init;
    assign inc_v[0]  = pinc;
    assign inc_v[1]  = minc;
    assign stride    = ADDR_W'(beat_bytes(size));

    for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cur_v[gi] <= '0;
            else if (load)
                cur_v[gi] <= init_v[gi];
            else if (step && inc_v[gi])
                cur_v[gi] <= cur_v[gi] + stride;
        end
    end

    assign src_addr = dir ? cur_v[1] : cur_v[0];
    assign dst_addr = dir ? cur_v[0] : cur_v[1];

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              m2m,
    input  logic              circ,
    input  logic              per_req,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [REG_DW-1:0] mem_rdata,
    output seq_state_t        state,
    output logic              load,
    output logic              rd_req,
    output logic              wr_req,
    output logic              step,
    output logic              stop,
    output logic              err_hit,
    output logic [REG_DW-1:0] data_q
);

    seq_state_t state_n;
    logic       cnt_zero;
    logic       last;

    assign cnt_zero = (cnt == '0);
    assign last     = (cnt == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (en && !cnt_zero) state_n = ST_ARM;
            ST_ARM: begin
                if (!en)                state_n = ST_IDLE;
                else if (m2m || per_req) state_n = ST_READ;
            end
            ST_READ:  if (mem_ack) state_n = mem_err ? ST_IDLE : ST_WRITE;
            ST_WRITE: if (mem_ack) state_n = mem_err ? ST_IDLE : ST_STEP;
            ST_STEP: begin
                if ((last && !circ) || !en) state_n = ST_IDLE;
                else                        state_n = ST_ARM;
            end
            default:  state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        load    = 1'b0;
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        step    = 1'b0;
        stop    = 1'b0;
        err_hit = 1'b0;
        unique case (state)
            ST_IDLE:  load = en && !cnt_zero;
            ST_ARM:   ;
            ST_READ: begin
                rd_req  = 1'b1;
                err_hit = mem_ack && mem_err;
                stop    = mem_ack && mem_err;
            end
            ST_WRITE: begin
                wr_req  = 1'b1;
                err_hit = mem_ack && mem_err;
                stop    = mem_ack && mem_err;
            end
            ST_STEP: begin
                step = 1'b1;
                stop = last && !circ;
                load = last && circ;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (state == ST_READ && mem_ack)
            data_q <= mem_rdata;
    end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int REG_AW = 8,
    parameter int CH_IDX = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                per_req,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [1:0]          mem_size,
    output logic [31:0]         mem_wdata,
    input  logic [31:0]         mem_rdata,
    input  logic                mem_ack,
    input  logic                mem_err,
    output logic                irq
);

    chan_cfg_t         cfg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] paddr_q, maddr_q, src_addr, dst_addr;
    logic [2:0]        flags_q;
    seq_state_t        seq_state;
    logic              load, rd_req, wr_req, step, stop, err_hit;

    dma_chan_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW), .CH_IDX(CH_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .step(step), .stop(stop), .err_hit(err_hit),
        .cfg_q(cfg_q), .cnt_q(cnt_q), .paddr_q(paddr_q), .maddr_q(maddr_q),
        .flags_q(flags_q), .irq(irq)
    );

    dma_chan_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load(load), .step(step),
        .dir(cfg_q.dir), .pinc(cfg_q.pinc), .minc(cfg_q.minc), .size(cfg_q.size),
        .paddr_init(paddr_q), .maddr_init(maddr_q),
        .src_addr(src_addr), .dst_addr(dst_addr)
    );

    dma_chan_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .en(cfg_q.en), .m2m(cfg_q.m2m), .circ(cfg_q.circ), .per_req(per_req),
        .cnt(cnt_q), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .state(seq_state), .load(load), .rd_req(rd_req), .wr_req(wr_req),
        .step(step), .stop(stop), .err_hit(err_hit), .data_q(mem_wdata)
    );

    assign mem_req  = rd_req | wr_req;
    assign mem_we   = wr_req;
    assign mem_addr = wr_req ? dst_addr : src_addr;
    assign mem_size = cfg_q.size;

endmodule

// File: rtl/dma_chan_ctrl_sva.sv
module dma_chan_ctrl_sva
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              per_req,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              mem_err,
    input logic              irq,
    input chan_cfg_t         cfg_q,
    input logic [2:0]        flags_q,
    input seq_state_t        seq_state
);

    always_comb begin
        if (!rst_n)
            assert_reset_quiet_R1: assert (!mem_req && !irq);
    end

    assert_wait_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_ARM && !per_req && !cfg_q.m2m) |=> !mem_req);

    assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && !mem_err) |=> (mem_req && mem_we));

    assert_error_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (!mem_req && !cfg_q.en));

    assert_irq_has_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags_q != 3'b000));

endmodule

bind dma_chan_ctrl dma_chan_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .per_req(per_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq),
    .cfg_q(cfg_q), .flags_q(flags_q), .seq_state(seq_state)
);

// File: tb/dma_chan_ctrl_test.sv
`timescale 1ns/1ps
module dma_chan_ctrl_test;

    localparam logic [7:0] A_STS = 8'h00, A_CLR = 8'h04, A_CFG = 8'h08,
                           A_CNT = 8'h0C, A_PA = 8'h10, A_MA = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        irq;

    always #10 clk = ~clk;   // 50 MHz

    dma_chan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
    );

    logic [7:0]  bmem [1024];
    logic [7:0]  rmem [1024];
    logic [31:0] wr_log [64];
    int          wr_beats = 0, rd_beats = 0;
    logic        err_on = 1'b0;
    logic [31:0] err_addr = '0;
    int          checks = 0, fails = 0;

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] mk_cfg(input logic en, done_ie, half_ie, err_ie,
                                           dir, circ, pinc, minc, input logic [1:0] sz,
                                           input logic m2m);
        return {21'd0, m2m, sz, minc, pinc, circ, dir, err_ie, half_ie, done_ie, en};
    endfunction

    // memory model: one acknowledge per request, answered on the falling edge
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req) begin
            mem_ack = 1'b1;
            if (err_on && mem_addr == err_addr) begin
                mem_err = 1'b1;
            end else if (mem_we) begin
                for (int b = 0; b < nbytes(mem_size); b++)
                    bmem[(mem_addr + b) & 1023] = mem_wdata[8*b +: 8];
                if (wr_beats < 64) wr_log[wr_beats] = mem_addr;
                wr_beats++;
            end else begin
                for (int b = 0; b < 4; b++)
                    mem_rdata[8*b +: 8] = bmem[(mem_addr + b) & 1023];
                rd_beats++;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = A_STS;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = A_STS;
    endtask

    // poll status until done or error; record write count when half first seen
    task automatic run_wait(output int half_at, output logic [31:0] sts);
        half_at = -1;
        sts = '0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            #1 sts = reg_rdata;
            if (sts[0] && half_at < 0) half_at = wr_beats;
            if (sts[1] || sts[2]) break;
        end
    endtask

    logic [31:0] rv, sts, src, dst, pa, ma;
    int          half_at, cnt, nb, mism;
    logic        dir, m2m, pinc, minc, sinc, dinc, hie, die;
    logic [1:0]  sz;

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) begin
            bmem[i] = 8'($urandom);
            rmem[i] = bmem[i];
        end
        repeat (3) @(negedge clk);
        #1;
        check("R1 mem_req in reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        rd_reg(A_STS, rv); check("R1 status", rv, 0);
        rd_reg(A_CFG, rv); check("R1 config", rv, 0);
        rd_reg(A_CNT, rv); check("R1 count", rv, 0);
        rd_reg(A_PA, rv);  check("R1 paddr", rv, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R2 and R4: register map, write blocking, request pacing
        wr_reg(A_PA, 32'h0000_0020);
        wr_reg(A_MA, 32'h0000_0220);
        wr_reg(A_CNT, 3);
        rd_reg(A_PA, rv); check("R2 paddr readback", rv, 32'h20);
        rd_reg(A_MA, rv); check("R2 maddr readback", rv, 32'h220);
        wr_reg(A_CFG, mk_cfg(1, 0, 0, 0, 0, 0, 1, 1, 2'd2, 0));
        wr_reg(A_CNT, 9);
        wr_reg(A_PA, 32'h44);
        repeat (20) @(negedge clk);
        check("R4 no beat without request", rd_beats, 0);
        rd_reg(A_CNT, rv); check("R2 count write ignored while enabled", rv, 3);
        rd_reg(A_PA, rv);  check("R2 addr write ignored while enabled", rv, 32'h20);
        for (int i = 0; i < 3; i++)
            for (int b = 0; b < 4; b++) rmem[32'h220 + 4*i + b] = rmem[32'h20 + 4*i + b];
        per_req = 1'b1;
        run_wait(half_at, sts);
        check("R5 status after paced run", sts, 32'hB);
        rd_reg(A_CNT, rv); check("R5 count zero", rv, 0);
        rd_reg(A_CFG, rv); check("R5 enable cleared", rv[0], 0);
        per_req = 1'b0;

        // randomized transfers
        for (int t = 0; t < 12; t++) begin
            wr_reg(A_CLR, 32'h8);
            rd_reg(A_STS, rv); check("R10 clear-all bit", rv, 0);
            dir = 1'($urandom); m2m = 1'($urandom); pinc = 1'($urandom);
            minc = 1'($urandom); sz = 2'($urandom); hie = 1'($urandom);
            die = 1'($urandom);
            cnt = 1 + ($urandom % 8);
            nb  = nbytes(sz);
            src = ($urandom % 32) * 4;
            dst = 32'h200 + ($urandom % 32) * 4;
            pa = dir ? dst : src;
            ma = dir ? src : dst;
            sinc = dir ? minc : pinc;
            dinc = dir ? pinc : minc;
            for (int i = 0; i < cnt; i++)
                for (int b = 0; b < nb; b++)
                    rmem[(dst + (dinc ? i*nb : 0) + b) & 1023] =
                        rmem[(src + (sinc ? i*nb : 0) + b) & 1023];
            wr_beats = 0;
            per_req = !m2m;
            wr_reg(A_PA, pa);
            wr_reg(A_MA, ma);
            wr_reg(A_CNT, cnt);
            wr_reg(A_CFG, mk_cfg(1, die, hie, 0, dir, 0, pinc, minc, sz, m2m));
            run_wait(half_at, sts);
            check("R5 status done+half", sts, 32'hB);
            check("R8 half flag position", half_at, cnt - cnt / 2);
            check("R5 beat count", wr_beats, cnt);
            check("R6 last write address", wr_log[cnt-1],
                  dst + (dinc ? (cnt-1)*nb : 0));
            check("R6 beat size", {30'd0, mem_size}, {30'd0, sz});
            check("R11 irq", {31'd0, irq}, {31'd0, hie | die});
            mism = 0;
            for (int i = 0; i < 1024; i++) if (bmem[i] !== rmem[i]) mism++;
            check("R3 memory image", mism, 0);
            per_req = 1'b0;
        end

        // R6: byte size, peripheral side incrementing as destination
        wr_reg(A_CLR, 32'h7);
        wr_beats = 0;
        for (int i = 0; i < 4; i++) rmem[32'h10 + i] = rmem[32'h280];
        wr_reg(A_PA, 32'h10);
        wr_reg(A_MA, 32'h280);
        wr_reg(A_CNT, 4);
        wr_reg(A_CFG, mk_cfg(1, 0, 0, 0, 1, 0, 1, 0, 2'd0, 1));
        run_wait(half_at, sts);
        check("R6 byte step 1", wr_log[1], 32'h11);
        check("R6 byte step 3", wr_log[3], 32'h13);

        // R7: circular reload, then leave circular mode mid-pass
        wr_reg(A_CLR, 32'h8);
        wr_beats = 0;
        wr_reg(A_PA, 32'h40);
        wr_reg(A_MA, 32'h300);
        wr_reg(A_CNT, 3);
        wr_reg(A_CFG, mk_cfg(1, 0, 0, 0, 0, 1, 1, 1, 2'd2, 1));
        for (int k = 0; k < 2000 && wr_beats < 5; k++) @(negedge clk);
        wr_reg(A_CFG, mk_cfg(1, 0, 0, 0, 0, 0, 1, 1, 2'd2, 1));
        for (int k = 0; k < 2000; k++) begin
            rd_reg(A_CFG, rv);
            if (!rv[0]) break;
        end
        check("R7 reload of dst addr", wr_log[3], 32'h300);
        check("R7 second pass step", wr_log[4], 32'h304);
        check("R7 stop at pass end", wr_beats, 6);
        rd_reg(A_CNT, rv); check("R7 count after exit", rv, 0);
        for (int i = 0; i < 12; i++) rmem[32'h300 + i] = rmem[32'h40 + i];

        // R9: error on third read
        wr_reg(A_CLR, 32'h8);
        wr_beats = 0;
        err_on = 1'b1;
        err_addr = 32'h48;
        wr_reg(A_PA, 32'h40);
        wr_reg(A_MA, 32'h380);
        wr_reg(A_CNT, 4);
        wr_reg(A_CFG, mk_cfg(1, 0, 0, 1, 0, 0, 1, 1, 2'd2, 1));
        run_wait(half_at, sts);
        for (int i = 0; i < 8; i++) rmem[32'h380 + i] = rmem[32'h40 + i];
        repeat (2) @(negedge clk);
        rd_reg(A_STS, rv); check("R9 status half+err", rv, 32'hD);
        rd_reg(A_CNT, rv); check("R9 count held", rv, 2);
        rd_reg(A_CFG, rv); check("R9 enable cleared", rv[0], 0);
        check("R9 no write after error", wr_beats, 2);
        check("R11 irq from error", {31'd0, irq}, 1);
        err_on = 1'b0;

        // R10: write-one-to-clear
        wr_reg(A_CLR, 32'h0);
        rd_reg(A_STS, rv); check("R10 zero write no effect", rv, 32'hD);
        wr_reg(A_CLR, 32'h1);
        rd_reg(A_STS, rv); check("R10 clear half only", rv, 32'hC);
        check("R11 irq still set", {31'd0, irq}, 1);
        wr_reg(A_CLR, 32'h4);
        rd_reg(A_STS, rv); check("R10 clear error", rv, 0);
        check("R11 irq cleared", {31'd0, irq}, 0);
        mism = 0;
        for (int i = 0; i < 1024; i++) if (bmem[i] !== rmem[i]) mism++;
        check("R3 final memory image", mism, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule